// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side and look at different information. The global component keeps a shift register of the most recent branch outcomes and uses it to index a table of 2-bit saturating counters. The local component works in two levels. The branch address selects one entry of a per-branch history table. The history held in that entry then indexes a table of 3-bit saturating counters. A third table of 2-bit chooser counters, also indexed by the global history, decides which component's answer becomes the prediction. The chooser is trained toward whichever component turned out to be right.

Predictions travel on a valid/ready stream. A request carries the branch address. The answer comes back on a response register one cycle after the request is accepted. If the consumer holds `rsp_ready` low, the response stays fixed and new requests are refused until it is taken. Resolved outcomes arrive on a plain update strobe that is accepted in every cycle. The default sizes are 4096 chooser counters, 4096 global counters with a 12-bit global history, 1024 local histories of 10 bits each, and 1024 local 3-bit counters. With these sizes the block holds 29 Kibit of state.

Top module: `tourney_pred`

## Requirements
- R1: After reset every history is zero. The global and chooser counters hold 1 and the local counters hold 3. So the first prediction is not-taken, and it is taken from the local component (`rsp_use_global` = 0).
- R2: The global counter and the chooser counter are both read at the index given by the global history. A 2-bit counter means taken when its value is 2 or more. A chooser value of 2 or more selects the global component, and a lower value selects the local one.
- R3: The local history entry is selected by address bits [11:2] of the PC. Its 10-bit value indexes the local counter table, and a 3-bit counter means taken when its value is 4 or more.
- R4: A valid update trains the global counter and the local counter that the updated branch currently maps to. Each moves one step up on taken and one step down on not-taken.
- R5: A valid update moves the chooser one step toward global when only the global component was right, and one step toward local when only the local component was right. The chooser is unchanged when both components were right or both were wrong.
- R6: After the counters are trained, the outcome is shifted into bit 0 of the global history and into bit 0 of the addressed local history entry. Bit i then means the branch i+1 updates ago was taken. Without an update, neither history changes.
- R7: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request gives `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds its value.
- R8: A prediction accepted in the same cycle as an update sees the tables and histories as they were before that update.
- R9: Counters saturate. Taken at the top value and not-taken at zero leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Prediction request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_pc | input | PC_W | Address of the branch to predict |
| rsp_valid | output | 1 | Response register holds a prediction |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| rsp_use_global | output | 1 | 1 when the global component supplied the answer |
| upd_valid | input | 1 | Resolved outcome present |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A prediction and an update can happen in the same cycle, possibly for the same branch address. In that case the prediction must use the state from before the update, while the update trains and shifts the histories. The bench drives such collisions, both on purpose and by random overlap of request, update and response stall. Each outcome is judged against a behavioural model that first computes the prediction from its old tables and then applies the update. Back-pressure can also overlap with these collisions, so the bench checks that a held response stays fixed while updates keep changing the tables underneath it.

// File: rtl/tourney_pkg.sv
package tourney_pkg;
  // counter helpers shared by the component tables
  function automatic int unsigned weak_nt(input int unsigned w);
    return (1 << (w - 1)) - 1;
  endfunction
endpackage

// File: rtl/sat_ctr_table.sv
module sat_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [CTR_W-1:0] rd_a_val,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [CTR_W-1:0] rd_b_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  import tourney_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] TOP  = '1;
  localparam logic [CTR_W-1:0] INIT = CTR_W'(weak_nt(CTR_W));

  logic [CTR_W-1:0] cells [DEPTH];
  logic [CTR_W-1:0] cur, nxt;

  assign rd_a_val = cells[rd_a_idx];
  assign rd_b_val = cells[rd_b_idx];
  assign cur      = cells[wr_idx];

  always_comb begin
    nxt = cur;
    if (wr_up && cur != TOP)        nxt = cur + 1'b1;
    else if (!wr_up && cur != '0)   nxt = cur - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= INIT;
    end else if (wr_en) begin
      cells[wr_idx] <= nxt;
    end
  end

  // without a write, a steadily addressed counter keeps its value
  p_hold_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && rd_a_idx == $past(rd_a_idx)) |-> rd_a_val == $past(rd_a_val));

  // a single step per write and saturation at the ends
  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_b_idx == $past(wr_idx)) |->
      (rd_b_val == $past(rd_b_val) + 1'b1 || rd_b_val == $past(rd_b_val) - 1'b1 ||
       (rd_b_val == $past(rd_b_val) && (rd_b_val == TOP || rd_b_val == '0))));
endmodule

// File: rtl/local_hist_table.sv
module local_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [HIST_W-1:0] rd_a_val,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [HIST_W-1:0] rd_b_val,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist [DEPTH];

  assign rd_a_val = hist[rd_a_idx];
  assign rd_b_val = hist[rd_b_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (wr_en) begin
      hist[wr_idx] <= {hist[wr_idx][HIST_W-2:0], wr_bit};
    end
  end

  // the newest outcome lands in bit 0 of the written entry
  p_lhist_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && rd_a_idx == $past(wr_idx)) |-> rd_a_val[0] == $past(wr_bit));
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter int GHIST_W   = 12,
  parameter int LHT_IDX_W = 10,
  parameter int LHIST_W   = 10,
  parameter int GCTR_W    = 2,
  parameter int LCTR_W    = 3,
  parameter int SEL_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PC_W-1:0] req_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic            rsp_use_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  logic [GHIST_W-1:0]   ghist;
  logic [LHT_IDX_W-1:0] p_lidx, u_lidx;
  logic [LHIST_W-1:0]   p_lhist, u_lhist;
  logic [GCTR_W-1:0]    g_p, g_u;
  logic [LCTR_W-1:0]    l_p, l_u;
  logic [SEL_W-1:0]     s_p, s_u;
  logic                 u_g_ok, u_l_ok, accept;
  logic                 p_dir;

  assign p_lidx = req_pc[PC_LSB +: LHT_IDX_W];
  assign u_lidx = upd_pc[PC_LSB +: LHT_IDX_W];

  local_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) lht_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(p_lidx), .rd_a_val(p_lhist),
    .rd_b_idx(u_lidx), .rd_b_val(u_lhist),
    .wr_en(upd_valid), .wr_idx(u_lidx), .wr_bit(upd_taken));

  sat_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) gtab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ghist), .rd_a_val(g_p),
    .rd_b_idx(ghist), .rd_b_val(g_u),
    .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken));

  sat_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) ltab_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(p_lhist), .rd_a_val(l_p),
    .rd_b_idx(u_lhist), .rd_b_val(l_u),
    .wr_en(upd_valid), .wr_idx(u_lhist), .wr_up(upd_taken));

  // component correctness at update time, from pre-update state
  assign u_g_ok = (g_u[GCTR_W-1] == upd_taken);
  assign u_l_ok = (l_u[LCTR_W-1] == upd_taken);

  sat_ctr_table #(.IDX_W(GHIST_W), .CTR_W(SEL_W)) sel_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ghist), .rd_a_val(s_p),
    .rd_b_idx(ghist), .rd_b_val(s_u),
    .wr_en(upd_valid && (u_g_ok != u_l_ok)), .wr_idx(ghist), .wr_up(u_g_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ghist <= '0;
    else if (upd_valid) ghist <= {ghist[GHIST_W-2:0], upd_taken};
  end

  // response stage
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign p_dir     = s_p[SEL_W-1] ? g_p[GCTR_W-1] : l_p[LCTR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_taken      <= 1'b0;
      rsp_use_global <= 1'b0;
    end else if (accept) begin
      rsp_valid      <= 1'b1;
      rsp_taken      <= p_dir;
      rsp_use_global <= s_p[SEL_W-1];
    end else if (rsp_ready) begin
      rsp_valid      <= 1'b0;
    end
  end

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_taken) && $stable(rsp_use_global)));

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_accept_gives_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_ghist_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  p_sel_neutral_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && u_g_ok == u_l_ok && !$past(upd_valid)) |=> $stable(s_u) || $changed(ghist));
endmodule

// File: tb/tourney_pred_tb.sv
module tourney_pred_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GW = 12;
  localparam int LIW = 10;
  localparam int LHW = 10;
  localparam int GN = 1 << GW;
  localparam int LIN = 1 << LIW;
  localparam int LHN = 1 << LHW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0, upd_valid = 0, upd_taken = 0;
  logic [31:0] req_pc = '0, upd_pc = '0;
  logic req_ready, rsp_valid, rsp_taken, rsp_use_global;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int m_g[GN], m_c[GN], m_l[LHN], m_lht[LIN];
  int m_gh;
  bit m_valid, m_taken, m_useg;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_pred dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
    .rsp_use_global(rsp_use_global),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < GN; i++) begin m_g[i] = 1; m_c[i] = 1; end
    for (int i = 0; i < LHN; i++) m_l[i] = 3;
    for (int i = 0; i < LIN; i++) m_lht[i] = 0;
    m_gh = 0; m_valid = 0; m_taken = 0; m_useg = 0;
  endtask

  function automatic int step(input int v, input bit up, input int top);
    if (up) return (v < top) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  // one clock edge of the behavioural reference, using the inputs just applied
  task automatic model_step();
    bit rdy;
    int li, lh;
    bit gok, lok;
    rdy = !m_valid || rsp_ready;
    if (req_valid && rdy) begin
      li = (req_pc >> 2) % LIN;
      lh = m_lht[li];
      m_useg  = (m_c[m_gh] >= 2);
      m_taken = m_useg ? (m_g[m_gh] >= 2) : (m_l[lh] >= 4);
      m_valid = 1;
    end else if (rsp_ready) begin
      m_valid = 0;
    end
    if (upd_valid) begin
      li = (upd_pc >> 2) % LIN;
      lh = m_lht[li];
      gok = ((m_g[m_gh] >= 2) == upd_taken);
      lok = ((m_l[lh] >= 4) == upd_taken);
      if (gok && !lok) m_c[m_gh] = step(m_c[m_gh], 1, 3);
      if (lok && !gok) m_c[m_gh] = step(m_c[m_gh], 0, 3);
      m_g[m_gh] = step(m_g[m_gh], upd_taken, 3);
      m_l[lh]   = step(m_l[lh], upd_taken, 7);
      m_lht[li] = ((lh << 1) | upd_taken) % LHN;
      m_gh      = ((m_gh << 1) | upd_taken) % GN;
    end
  endtask

  task automatic compare();
    check("rsp_valid", rsp_valid, m_valid);
    check("req_ready", req_ready, (!m_valid || rsp_ready));
    if (m_valid) begin
      check("rsp_taken", rsp_taken, m_taken);
      check("rsp_use_global", rsp_use_global, m_useg);
    end
  endtask

  task automatic drive(input bit rv, input logic [31:0] rpc, input bit rr,
                       input bit uv, input logic [31:0] upc, input bit ut);
    req_valid = rv; req_pc = rpc; rsp_ready = rr;
    upd_valid = uv; upd_pc = upc; upd_taken = ut;
    @(negedge clk);
    model_step();
    compare();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at the ports, then the first prediction
    tag = "R1";
    check("rsp_valid after reset", rsp_valid, 0);
    check("req_ready after reset", req_ready, 1);
    drive(1, 32'h100, 1, 0, 0, 0);
    check("first prediction direction", rsp_taken, 0);
    check("first prediction source", rsp_use_global, 0);

    // R3 R4 R6: a loop branch with a period-4 pattern, predict then resolve
    tag = "R3 R4 R6 loop";
    for (int it = 0; it < 40; it++) begin
      bit t;
      t = (it % 4) != 3;
      drive(1, 32'h240, 1, 0, 0, 0);
      drive(0, 0, 1, 1, 32'h240, t);
    end

    // R2 R5: two branches correlated through the global history
    tag = "R2 R5 correlated";
    for (int it = 0; it < 60; it++) begin
      bit a;
      a = (it % 3) == 0;
      drive(1, 32'h400, 1, 1, 32'h400, a);
      drive(1, 32'h808, 1, 1, 32'h808, a);
    end

    // R9: long taken run then long not-taken run on one branch
    tag = "R9 saturation";
    for (int it = 0; it < 24; it++) drive(1, 32'h3c, 1, 1, 32'h3c, 1);
    for (int it = 0; it < 24; it++) drive(1, 32'h3c, 1, 1, 32'h3c, 0);

    // R8: request and update for the same branch in one cycle
    tag = "R8 collision";
    for (int it = 0; it < 30; it++) drive(1, 32'h5a4, 1, 1, 32'h5a4, it[0]);

    // R7: back-pressure held for several cycles with updates underneath
    tag = "R7 stall";
    drive(1, 32'h240, 0, 0, 0, 0);
    for (int it = 0; it < 5; it++) drive(1, 32'h240, 0, 1, 32'h240, 1);
    drive(0, 0, 1, 0, 0, 0);

    // R2 R7 R8: random mix of requests, updates and stalls over aliasing PCs
    tag = "R2 R7 R8 random";
    for (int it = 0; it < 3000; it++) begin
      logic [31:0] a, b;
      a = 32'(($urandom % 16) * 4 + 32'h1000 * ($urandom % 2));
      b = 32'(($urandom % 16) * 4 + 32'h1000 * ($urandom % 2));
      drive(bit'($urandom % 2), a, bit'(($urandom % 4) != 0),
            bit'($urandom % 2), b, bit'(($urandom % 3) != 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule